// File: doc/BRIEF.md
# Raster Subpanel Pixel Substitution

This block sits in the pixel path of a raster display controller, between the pixel source and the panel output stage. It splits every frame into an upper region and a lower region by line number. One region carries the live video pixels unchanged. In the other region every valid pixel is replaced with a programmable 24-bit fill colour. A polarity input selects which region gets the fill colour. Substitution is only permitted when the controller drives an active-matrix panel.

The size of the lower region is given as an 11-bit code that holds the line count minus one. The block counts lines from a frame-start strobe and advances on line-end strobes. All configuration is captured on the first pixel of each frame, so the split never moves partway through a frame. The output stream is a copy of the input stream delayed by one register stage, with the fill colour substituted where required.

The line tracker is a three-state machine. `SP_WAIT` is the state after reset, before any frame start has been seen; every pixel passes through. `SP_TOP` means the current line lies above the split. `SP_BOTTOM` means the current line lies at or below the split. Transitions:
- WAIT→TOP or WAIT→BOTTOM on the first frame start, chosen by where line 0 falls.
- TOP→BOTTOM on the line end that moves the line index onto the split.
- BOTTOM→TOP or BOTTOM→BOTTOM, and TOP→TOP or TOP→BOTTOM, on every later frame start, chosen by where line 0 falls in the new frame.
- Every state holds when neither strobe is accepted.

Top module: `raster_subpanel`

## Requirements
- R1: When `sp_enable` is 0, every output pixel equals the input pixel of the previous cycle.
- R2: When `tft_mode` is 0, every pixel passes through unchanged even if `sp_enable` is 1.
- R3: A `split_code` of N makes the lower region N+1 lines. The lower region is lines with index at least `panel_lines` − (N+1), and the lines above it form the upper region.
- R4: The line index is 0 on the pixel that carries an accepted frame start. It rises by one after each accepted line end and saturates at 2^12−1.
- R5: With `dflt_on_bottom` = 0, valid pixels in the upper region are replaced by the fill colour, and lower-region pixels are live video.
- R6: With `dflt_on_bottom` = 1, upper-region pixels are live video, and valid pixels in the lower region are replaced by the fill colour.
- R7: The fill colour is {`dflt_hi`[7:0], `dflt_lo`[15:0]`}`: `dflt_hi` in bits 23:16 and `dflt_lo` in bits 15:0.
- R8: When N+1 is at least `panel_lines`, every line of the frame is in the lower region.
- R9: The enable, mode, polarity, split code, panel line count and fill colour are sampled on the pixel with an accepted frame start. Changes to them take effect only at the next accepted frame start.
- R10: `out_valid`, `out_frame`, `out_line_end` and `out_pixel` follow the inputs with exactly one cycle of latency on both the substituted and the pass-through path. All four outputs are 0 after reset.
- R11: Before the first accepted frame start after reset, all pixels pass through unchanged.
- R12: `in_frame` and `in_line_end` are accepted only together with `in_valid` = 1. Unaccepted strobes do not change the line index, and pixels with `in_valid` = 0 are never substituted. The strobes themselves are still forwarded to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_enable | input | 1 | Subpanel substitution enable |
| tft_mode | input | 1 | Active-matrix panel mode flag |
| dflt_on_bottom | input | 1 | 0: fill in upper region, 1: fill in lower region |
| split_code | input | 11 | Lower-region line count minus one |
| panel_lines | input | 12 | Total lines per frame |
| dflt_lo | input | 16 | Fill colour bits 15:0 |
| dflt_hi | input | 8 | Fill colour bits 23:16 |
| in_valid | input | 1 | Input pixel valid |
| in_frame | input | 1 | First pixel of a frame |
| in_line_end | input | 1 | Last pixel of a line |
| in_pixel | input | 24 | Input pixel data |
| out_valid | output | 1 | Registered valid |
| out_frame | output | 1 | Registered frame start |
| out_line_end | output | 1 | Registered line end |
| out_pixel | output | 24 | Registered, possibly substituted, pixel |

## Verification
The assertions assume three things about the inputs. Frame starts and line ends mark pixels with `in_valid` high when they are meant to count. The configuration is free to change at any time. Frames stay well below the saturation point of the line counter, so the region bookkeeping of the state machine can be compared against a plain index comparison.

The stimulus keeps within these assumptions as follows. Frames are built line by line with random invalid gaps. Stray strobes appear only on invalid cycles. Panels are at most a few dozen lines. Configuration changes are made both between frames and in the middle of a frame.

// File: rtl/raster_subpanel_pkg.sv
package raster_subpanel_pkg;

    // Region tracking states of the line state machine
    typedef enum logic [1:0] {
        SP_WAIT   = 2'd0,
        SP_TOP    = 2'd1,
        SP_BOTTOM = 2'd2
    } sp_state_e;

    // Saturating increment of a line index held in 12 bits
    function automatic logic [11:0] sat_inc12(input logic [11:0] v);
        return (v == 12'hFFF) ? v : v + 12'd1;
    endfunction

endpackage

// File: rtl/sp_cfg_sample.sv
module sp_cfg_sample #(
    parameter int THR_W  = 11,
    parameter int LINE_W = 12,
    parameter int PIX_W  = 24,
    parameter int DLO_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_go,
    input  logic                      sp_enable,
    input  logic                      tft_mode,
    input  logic                      dflt_on_bottom,
    input  logic [THR_W-1:0]          split_code,
    input  logic [LINE_W-1:0]         panel_lines,
    input  logic [DLO_W-1:0]          dflt_lo,
    input  logic [PIX_W-DLO_W-1:0]    dflt_hi,
    output logic                      act_now,
    output logic                      pos_now,
    output logic [LINE_W-1:0]         bnd_now,
    output logic [PIX_W-1:0]          dflt_now
);
    localparam int DHI_W = PIX_W - DLO_W;

    logic [LINE_W-1:0] dec_lines;
    logic [LINE_W-1:0] live_bnd;
    logic              live_act;
    logic [PIX_W-1:0]  live_dflt;

    logic              held_act;
    logic              held_pos;
    logic [LINE_W-1:0] held_bnd;
    logic [PIX_W-1:0]  held_dflt;

    // Decode the minus-one line count and place the split
    always_comb begin
        dec_lines = LINE_W'(split_code) + LINE_W'(1);
        if (dec_lines >= panel_lines) begin
            live_bnd = '0;
        end else begin
            live_bnd = panel_lines - dec_lines;
        end
        live_act  = sp_enable & tft_mode;
        live_dflt = {dflt_hi[DHI_W-1:0], dflt_lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_act  <= 1'b0;
            held_pos  <= 1'b0;
            held_bnd  <= '0;
            held_dflt <= '0;
        end else if (frame_go) begin
            held_act  <= live_act;
            held_pos  <= dflt_on_bottom;
            held_bnd  <= live_bnd;
            held_dflt <= live_dflt;
        end
    end

    // The frame-start pixel itself already uses the fresh settings
    always_comb begin
        act_now  = frame_go ? live_act       : held_act;
        pos_now  = frame_go ? dflt_on_bottom : held_pos;
        bnd_now  = frame_go ? live_bnd       : held_bnd;
        dflt_now = frame_go ? live_dflt      : held_dflt;
    end

    // R9: settings stay frozen between frame starts
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_go |=> ($stable(held_act) && $stable(held_pos)
                       && $stable(held_bnd) && $stable(held_dflt)));

    // R2: without active-matrix mode the captured activity flag is clear
    a_r2_tft_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && !tft_mode) |=> !held_act);

endmodule

// File: rtl/sp_line_fsm.sv
module sp_line_fsm #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    input  logic              line_go,
    input  logic [LINE_W-1:0] bnd_now,
    output logic              started,
    output logic              in_bottom
);
    import raster_subpanel_pkg::*;

    localparam logic [LINE_W-1:0] IDX_MAX = {LINE_W{1'b1}};

    sp_state_e         state_q, state_d;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] idx;
    logic [LINE_W-1:0] next_idx;
    sp_state_e         region_next;

    // Index of the current pixel and of the next one
    always_comb begin
        idx = frame_go ? '0 : line_q;
        if (line_go && idx != IDX_MAX) begin
            next_idx = idx + LINE_W'(1);
        end else begin
            next_idx = idx;
        end
        region_next = (next_idx >= bnd_now) ? SP_BOTTOM : SP_TOP;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SP_WAIT: begin
                if (frame_go) begin
                    state_d = region_next;
                end
            end
            SP_TOP: begin
                if (frame_go || line_go) begin
                    state_d = region_next;
                end
            end
            SP_BOTTOM: begin
                if (frame_go) begin
                    state_d = region_next;
                end
            end
            default: state_d = SP_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SP_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Line index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (frame_go || state_q != SP_WAIT) begin
            line_q <= next_idx;
        end
    end

    // Outputs for the current pixel
    always_comb begin
        started   = frame_go || (state_q != SP_WAIT);
        in_bottom = frame_go ? (bnd_now == '0) : (state_q == SP_BOTTOM);
    end

    // R4: a frame start restarts the index
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> (line_q == ($past(line_go) ? LINE_W'(1) : LINE_W'(0))));

    // R12: without accepted strobes the index holds
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_go && !line_go) |=> $stable(line_q));

    // R8: a zero split point puts line 0 in the lower region
    a_r8_all_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && bnd_now == '0) |=> (state_q == SP_BOTTOM));

    // R3: state region agrees with a plain index comparison
    a_r3_region_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SP_WAIT && !frame_go && line_q != IDX_MAX)
            |-> ((state_q == SP_BOTTOM) == (line_q >= bnd_now)));

    // R11: once left, the waiting state is never re-entered
    a_r11_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SP_WAIT) |=> (state_q != SP_WAIT));

endmodule

// File: rtl/sp_pix_out.sv
module sp_pix_out #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_frame,
    input  logic             in_line_end,
    input  logic [PIX_W-1:0] in_pixel,
    input  logic             subst,
    input  logic [PIX_W-1:0] fill,
    output logic             out_valid,
    output logic             out_frame,
    output logic             out_line_end,
    output logic [PIX_W-1:0] out_pixel
);
    logic [PIX_W-1:0] pix_sel;

    always_comb begin
        pix_sel = subst ? fill : in_pixel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_frame    <= 1'b0;
            out_line_end <= 1'b0;
            out_pixel    <= '0;
        end else begin
            out_valid    <= in_valid;
            out_frame    <= in_frame;
            out_line_end <= in_line_end;
            out_pixel    <= pix_sel;
        end
    end

endmodule

// File: rtl/raster_subpanel.sv
module raster_subpanel #(
    parameter int THR_W  = 11,
    parameter int LINE_W = 12,
    parameter int PIX_W  = 24,
    parameter int DLO_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sp_enable,
    input  logic                   tft_mode,
    input  logic                   dflt_on_bottom,
    input  logic [THR_W-1:0]       split_code,
    input  logic [LINE_W-1:0]      panel_lines,
    input  logic [DLO_W-1:0]       dflt_lo,
    input  logic [PIX_W-DLO_W-1:0] dflt_hi,
    input  logic                   in_valid,
    input  logic                   in_frame,
    input  logic                   in_line_end,
    input  logic [PIX_W-1:0]       in_pixel,
    output logic                   out_valid,
    output logic                   out_frame,
    output logic                   out_line_end,
    output logic [PIX_W-1:0]       out_pixel
);
    logic              frame_go;
    logic              line_go;
    logic              act_now;
    logic              pos_now;
    logic [LINE_W-1:0] bnd_now;
    logic [PIX_W-1:0]  dflt_now;
    logic              started;
    logic              in_bottom;
    logic              subst;

    // Strobes count only with a valid pixel
    always_comb begin
        frame_go = in_frame & in_valid;
        line_go  = in_line_end & in_valid;
    end

    sp_cfg_sample #(
        .THR_W (THR_W),
        .LINE_W(LINE_W),
        .PIX_W (PIX_W),
        .DLO_W (DLO_W)
    ) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_go      (frame_go),
        .sp_enable     (sp_enable),
        .tft_mode      (tft_mode),
        .dflt_on_bottom(dflt_on_bottom),
        .split_code    (split_code),
        .panel_lines   (panel_lines),
        .dflt_lo       (dflt_lo),
        .dflt_hi       (dflt_hi),
        .act_now       (act_now),
        .pos_now       (pos_now),
        .bnd_now       (bnd_now),
        .dflt_now      (dflt_now)
    );

    sp_line_fsm #(
        .LINE_W(LINE_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_go (frame_go),
        .line_go  (line_go),
        .bnd_now  (bnd_now),
        .started  (started),
        .in_bottom(in_bottom)
    );

    always_comb begin
        subst = in_valid & started & act_now & (in_bottom == pos_now);
    end

    sp_pix_out #(
        .PIX_W(PIX_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_frame    (in_frame),
        .in_line_end (in_line_end),
        .in_pixel    (in_pixel),
        .subst       (subst),
        .fill        (dflt_now),
        .out_valid   (out_valid),
        .out_frame   (out_frame),
        .out_line_end(out_line_end),
        .out_pixel   (out_pixel)
    );

    // R1: inactive substitution means pass-through
    a_r1_pass_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !act_now |=> (out_pixel == $past(in_pixel)));

    // R5: fill colour in the upper region when polarity is 0
    a_r5_top_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && started && act_now && !pos_now && !in_bottom)
            |=> (out_pixel == $past(dflt_now)));

    // R6: fill colour in the lower region when polarity is 1
    a_r6_bottom_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && started && act_now && pos_now && in_bottom)
            |=> (out_pixel == $past(dflt_now)));

    // R10: strobes and valid are delayed by one cycle
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid) && out_frame == $past(in_frame)
                  && out_line_end == $past(in_line_end)));

    // R12: invalid pixels are never replaced
    a_r12_invalid_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (out_pixel == $past(in_pixel)));

endmodule

// File: tb/sim_raster_subpanel.sv
`timescale 1ns/1ps
module sim_raster_subpanel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sp_enable = 1'b0;
    logic        tft_mode = 1'b0;
    logic        dflt_on_bottom = 1'b0;
    logic [10:0] split_code = '0;
    logic [11:0] panel_lines = '0;
    logic [15:0] dflt_lo = '0;
    logic [7:0]  dflt_hi = '0;
    logic        in_valid = 1'b0;
    logic        in_frame = 1'b0;
    logic        in_line_end = 1'b0;
    logic [23:0] in_pixel = '0;
    logic        out_valid;
    logic        out_frame;
    logic        out_line_end;
    logic [23:0] out_pixel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    bit          m_started = 1'b0;
    bit          m_act = 1'b0;
    bit          m_pos = 1'b0;
    int          m_bnd = 0;
    logic [23:0] m_dflt = '0;
    int          m_line = 0;

    always #2 clk = ~clk;

    raster_subpanel u0 (
        .clk(clk), .rst_n(rst_n), .sp_enable(sp_enable), .tft_mode(tft_mode),
        .dflt_on_bottom(dflt_on_bottom), .split_code(split_code),
        .panel_lines(panel_lines), .dflt_lo(dflt_lo), .dflt_hi(dflt_hi),
        .in_valid(in_valid), .in_frame(in_frame), .in_line_end(in_line_end),
        .in_pixel(in_pixel), .out_valid(out_valid), .out_frame(out_frame),
        .out_line_end(out_line_end), .out_pixel(out_pixel)
    );

    // Split point from the requirements (R3, R8)
    function automatic int calc_bnd(input int code, input int total);
        int lines;
        lines = code + 1;
        return (lines >= total) ? 0 : total - lines;
    endfunction

    // Expected output pixel (R1, R2, R5, R6, R7, R11, R12)
    function automatic logic [23:0] exp_pixel(input bit v, input int idx,
                                              input logic [23:0] d);
        bit bot;
        bot = (idx >= m_bnd);
        if (v && m_started && m_act && (bot == m_pos)) return m_dflt;
        return d;
    endfunction

    task automatic cyc(input bit v, input bit fs, input bit le,
                       input logic [23:0] d, input string tag);
        int idx;
        logic [23:0] e;
        if (v && fs) begin
            m_started = 1'b1;
            m_act  = sp_enable && tft_mode;
            m_pos  = dflt_on_bottom;
            m_bnd  = calc_bnd(int'(split_code), int'(panel_lines));
            m_dflt = {dflt_hi, dflt_lo};
            idx = 0;
        end else begin
            idx = m_line;
        end
        e = exp_pixel(v, idx, d);
        in_valid = v; in_frame = fs; in_line_end = le; in_pixel = d;
        @(posedge clk);
        #1;
        n_run++;
        if (out_valid !== v || out_frame !== fs || out_line_end !== le
            || out_pixel !== e) begin
            n_fail++;
            $display("FAIL %s: out v/f/l/pix=%0b/%0b/%0b/%06h expected %0b/%0b/%0b/%06h",
                     tag, out_valid, out_frame, out_line_end, out_pixel, v, fs, le, e);
        end
        if (v && fs) m_line = le ? 1 : 0;
        else if (v && le && m_started) m_line = (idx >= 4095) ? 4095 : idx + 1;
    endtask

    // One frame; optional invalid gaps with stray strobes (R12),
    // optional configuration change after the first pixel (R9)
    task automatic frame(input int lines, input int ppl, input bit gaps,
                         input bit mid_change, input string tag);
        for (int l = 0; l < lines; l++) begin
            for (int p = 0; p < ppl; p++) begin
                if (gaps && ($urandom % 3) == 0)
                    cyc(1'b0, $urandom % 2, $urandom % 2, $urandom, tag);
                cyc(1'b1, (l == 0 && p == 0), (p == ppl - 1), $urandom, tag);
                if (mid_change && l == 0 && p == 0) begin
                    dflt_on_bottom = ~dflt_on_bottom;
                    split_code = 11'd0;
                    sp_enable = ~sp_enable;
                    dflt_lo = ~dflt_lo;
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        n_run++;
        if (out_valid !== 1'b0 || out_frame !== 1'b0 || out_line_end !== 1'b0
            || out_pixel !== 24'h0) begin
            n_fail++;
            $display("FAIL R10 reset: %0b/%0b/%0b/%06h expected 0/0/0/000000",
                     out_valid, out_frame, out_line_end, out_pixel);
        end
        rst_n = 1'b1;
        sp_enable = 1; tft_mode = 1; dflt_on_bottom = 0;
        split_code = 11'd2; panel_lines = 12'd8;
        dflt_hi = 8'hA5; dflt_lo = 16'h3C7E;
        // R11: pixels before any frame start pass through
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, (i % 2), $urandom, "R11");
        // R3, R5, R7: upper 5 lines filled, lower 3 live
        frame(8, 3, 1'b0, 1'b0, "R3/R5/R7");
        // R6: polarity 1 fills the lower region
        dflt_on_bottom = 1;
        frame(8, 3, 1'b0, 1'b0, "R6");
        // R3: a single-line lower region
        split_code = 11'd0;
        frame(6, 2, 1'b0, 1'b0, "R3 one line");
        // R8: decoded count equal to and beyond the panel size
        split_code = 11'd7; dflt_on_bottom = 1;
        frame(8, 2, 1'b0, 1'b0, "R8 equal");
        split_code = 11'd2047; dflt_on_bottom = 0;
        frame(5, 2, 1'b0, 1'b0, "R8 beyond");
        // R1: disabled
        sp_enable = 0; split_code = 11'd3;
        frame(7, 2, 1'b0, 1'b0, "R1");
        // R2: enabled without active-matrix mode
        sp_enable = 1; tft_mode = 0;
        frame(7, 2, 1'b0, 1'b0, "R2");
        tft_mode = 1;
        // R9: mid-frame change, then the next frame picks it up
        split_code = 11'd3; dflt_on_bottom = 0;
        frame(8, 2, 1'b0, 1'b1, "R9 held");
        frame(8, 2, 1'b0, 1'b0, "R9 next");
        // R12: stray strobes on invalid cycles
        sp_enable = 1; split_code = 11'd4; dflt_on_bottom = 1;
        frame(9, 3, 1'b1, 1'b0, "R12");
        // R4: random frames, back to back
        for (int f = 0; f < 40; f++) begin
            sp_enable = ($urandom % 5) != 0;
            tft_mode = ($urandom % 5) != 0;
            dflt_on_bottom = $urandom % 2;
            split_code = 11'($urandom % 14);
            panel_lines = 12'(1 + $urandom % 12);
            dflt_hi = 8'($urandom); dflt_lo = 16'($urandom);
            frame(int'(panel_lines), 1 + $urandom % 4, $urandom % 2,
                  ($urandom % 6) == 0, "R4 random");
        end
        // R10: idle cycles drain with zero strobes
        cyc(1'b0, 1'b0, 1'b0, 24'h123456, "R10 idle");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule